// File: doc/BRIEF.md
# Prioritised Daisy-Chain Interrupter

This block lets a board raise an interrupt on a backplane that carries seven shared, prioritised, active-low request lines. An internal event sets a pending request. While the request is pending, the block pulls low the single request line that matches its programmed level. The request stays up until an interrupt handler acknowledges it or the block is reset. A programmed level of zero turns the interrupter off.

The handler answers with an acknowledge cycle. It lowers the address strobe, places the level it is serving on three address lines, and sends an acknowledge token down a daisy chain. Each board takes the token on its chain input. If the board holds a pending request at the level being served, it keeps the token: its chain output stays high, it drives its status/ID byte, asserts the transfer acknowledge and drops its request. Any other board passes the token to its chain output and stays off the data lines.

Boards that share a level are therefore served in chain order. The board nearest the handler answers first, and the boards further down keep their requests for a later acknowledge cycle.

Top module: `irqd_interrupter`

## Requirements
- R1: After reset, all request lines are high, the chain output is high, the transfer acknowledge is high and the data drive enable is low.
- R2: An event with programmed level L (1 to 7) pulls request line bit L-1 low one clock later. All other request bits stay high.
- R3: With programmed level 0, an event is ignored and every request line stays high.
- R4: A pending request stays asserted on every following clock until it is acknowledged or reset.
- R5: The handler runs an acknowledge cycle by holding address strobe low with the chain input low. If the block is pending and the acknowledged level equals its programmed level, then one clock later it asserts the transfer acknowledge, drives its status/ID byte with the drive enable high, and keeps its chain output high.
- R6: The request line is released on the same clock on which the transfer acknowledge is asserted.
- R7: In an acknowledge cycle where the block is not pending, or the level does not match, the chain output goes low one clock later. The transfer acknowledge stays high, the data drive enable stays low and the data bus reads zero. A pending request keeps its line asserted.
- R8: The decision to serve or pass is taken on the first clock of the cycle and held until the address strobe rises, even if the acknowledged level changes. All outputs return to idle one clock after the address strobe rises.
- R9: When two chained boards request at the same level, the upstream board answers the first acknowledge cycle and the downstream board keeps its request. The downstream board answers the next cycle, after the token has passed through the upstream board.
- R10: An event on the same clock on which an acknowledge is taken re-arms the request, so the line stays asserted after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 3 | Programmed request level, 0 disables |
| cfg_status_id | input | 8 | Status/ID byte returned when served |
| event_i | input | 1 | Internal interrupt event, one clock per event |
| irq_n | output | 7 | Request lines, bit i is level i+1, active low |
| as_n | input | 1 | Address strobe, active low |
| ack_level | input | 3 | Level being acknowledged (address lines 3:1) |
| iackin_n | input | 1 | Acknowledge chain input, active low |
| iackout_n | output | 1 | Acknowledge chain output, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| data_o | output | 8 | Status/ID byte, zero when not driving |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The bench covers the two outer levels, 1 and 7. A decoder that is off by one, or that flips the bit order, would pull the wrong line low. It serves a cycle whose acknowledged level changes halfway through; a design that re-decides on every clock would drop the acknowledge or start passing the token. Two chained boards share one level, so that a downstream board that answers too early, or an upstream board that forwards the token while it is serving, shows up as the wrong acknowledge or the wrong byte. An event that lands on the clock where the acknowledge is taken checks that clearing does not override a new request; if it did, the second interrupt would be lost.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_PASS  = 2'd1,
      CH_SERVE = 2'd2
   } chain_st_e;
endpackage

// File: rtl/irqd_request.sv
// Pending-request holder and level decoder onto the shared request lines.
module irqd_request #(
   parameter int NUM_LEVELS = 7,
   parameter int LVL_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LVL_W-1:0]      level,
   input  logic                  event_i,
   input  logic                  take_i,
   output logic                  pending_o,
   output logic [NUM_LEVELS-1:0] irq_n_o
);
   logic pending_q, pending_d, enabled;

   assign enabled   = (level != '0);
   // clearing on acknowledge loses to a fresh event (R10)
   assign pending_d = (pending_q & ~take_i) | (event_i & enabled);

   always_ff @(posedge clk) begin
      if (!rst_n) pending_q <= 1'b0;
      else        pending_q <= pending_d;
   end

   assign pending_o = pending_q;

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_line
      assign irq_n_o[g] = ~(pending_q && (level == LVL_W'(g + 1)));
   end

   a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~irq_n_o));
   a_r3_disabled_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending_o && level == '0) |=> !pending_o);
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_o && !take_i) |=> pending_o);
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !event_i) |=> !pending_o);
endmodule

// File: rtl/irqd_ack_fsm.sv
// Acknowledge-cycle decision: serve, pass the token, or stay idle.
module irqd_ack_fsm
   import irqd_pkg::*;
#(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             as_n,
   input  logic             iackin_n,
   input  logic [LVL_W-1:0] ack_level,
   input  logic [LVL_W-1:0] level,
   input  logic             pending,
   output logic             take_o,
   output logic             serve_o,
   output logic             pass_o
);
   chain_st_e st_q, st_d;
   logic      in_cycle, hit;

   assign in_cycle = ~as_n & ~iackin_n;
   assign hit      = pending && (level != '0) && (ack_level == level);

   always_comb begin
      st_d   = st_q;
      take_o = 1'b0;
      case (st_q)
         CH_IDLE: if (in_cycle) begin
            if (hit) begin
               st_d   = CH_SERVE;
               take_o = 1'b1;
            end else begin
               st_d = CH_PASS;
            end
         end
         CH_PASS:  if (!in_cycle) st_d = CH_IDLE;
         CH_SERVE: if (as_n)      st_d = CH_IDLE;
         default:  st_d = CH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= CH_IDLE;
      else        st_q <= st_d;
   end

   assign serve_o = (st_q == CH_SERVE);
   assign pass_o  = (st_q == CH_PASS);

   a_r7_pass_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> $past(!iackin_n && !as_n));
   a_r8_serve_held: assert property (@(posedge clk) disable iff (!rst_n)
      (serve_o && !as_n) |=> serve_o);
   a_r5_serve_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(serve_o) |-> $past(pending && level != '0 && ack_level == level));
endmodule

// File: rtl/irqd_status_drv.sv
// Captures the status/ID when the acknowledge is taken and drives the data bus.
module irqd_status_drv #(
   parameter int ID_W      = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_i,
   input  logic            serve_i,
   input  logic [ID_W-1:0] status_id,
   output logic [ID_W-1:0] data_o,
   output logic            data_oe_o,
   output logic            dtack_n_o
);
   logic [ID_W-1:0] id_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      id_q <= '0;
      else if (take_i) id_q <= status_id;
   end

   assign data_oe_o = serve_i;
   assign dtack_n_o = ~serve_i;

   if (PARK_ZERO) begin : g_park_zero
      assign data_o = serve_i ? id_q : '0;
   end else begin : g_park_hold
      assign data_o = id_q;
   end
endmodule

// File: rtl/irqd_interrupter.sv
// Interrupter with level select, request hold and acknowledge daisy chain.
module irqd_interrupter #(
   parameter int NUM_LEVELS = 7,
   parameter int ID_W       = 8,
   parameter bit PARK_ZERO  = 1'b1,
   localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LVL_W-1:0]      cfg_level,
   input  logic [ID_W-1:0]       cfg_status_id,
   input  logic                  event_i,
   output logic [NUM_LEVELS-1:0] irq_n,
   input  logic                  as_n,
   input  logic [LVL_W-1:0]      ack_level,
   input  logic                  iackin_n,
   output logic                  iackout_n,
   output logic                  dtack_n,
   output logic [ID_W-1:0]       data_o,
   output logic                  data_oe
);
   if (NUM_LEVELS < 1) begin : g_bad_levels
      $error("irqd_interrupter: NUM_LEVELS must be at least 1");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("irqd_interrupter: ID_W must be at least 1");
   end

   logic pending, take, serve, pass;

   irqd_request #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_req (
      .clk(clk), .rst_n(rst_n), .level(cfg_level), .event_i(event_i),
      .take_i(take), .pending_o(pending), .irq_n_o(irq_n));

   irqd_ack_fsm #(.LVL_W(LVL_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .iackin_n(iackin_n),
      .ack_level(ack_level), .level(cfg_level), .pending(pending),
      .take_o(take), .serve_o(serve), .pass_o(pass));

   irqd_status_drv #(.ID_W(ID_W), .PARK_ZERO(PARK_ZERO)) u_drv (
      .clk(clk), .rst_n(rst_n), .take_i(take), .serve_i(serve),
      .status_id(cfg_status_id), .data_o(data_o), .data_oe_o(data_oe),
      .dtack_n_o(dtack_n));

   assign iackout_n = ~pass;

   a_r5_serve_blocks_chain: assert property (@(posedge clk) disable iff (!rst_n)
      !dtack_n |-> iackout_n);
   a_r7_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !iackout_n |-> (!data_oe && dtack_n));
   a_r8_idle_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (as_n && $past(as_n)) |-> (dtack_n && iackout_n));
endmodule

// File: tb/tb_irqd_interrupter.sv
module tb_irqd_interrupter;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [2:0] lvl_a = 3'd0, lvl_b = 3'd0, ack_lvl = 3'd0;
   logic [7:0] id_a = 8'hA5, id_b = 8'h3C;
   logic       ev_a = 1'b0, ev_b = 1'b0, as_n = 1'b1, chain_in_n = 1'b1;
   logic [6:0] irq_a, irq_b;
   logic       ackout_a, ackout_b, dtack_a, dtack_b, oe_a, oe_b;
   logic [7:0] data_a, data_b;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   irqd_interrupter dut (
      .clk(clk), .rst_n(rst_n), .cfg_level(lvl_a), .cfg_status_id(id_a),
      .event_i(ev_a), .irq_n(irq_a), .as_n(as_n), .ack_level(ack_lvl),
      .iackin_n(chain_in_n), .iackout_n(ackout_a), .dtack_n(dtack_a),
      .data_o(data_a), .data_oe(oe_a));

   irqd_interrupter dut2 (
      .clk(clk), .rst_n(rst_n), .cfg_level(lvl_b), .cfg_status_id(id_b),
      .event_i(ev_b), .irq_n(irq_b), .as_n(as_n), .ack_level(ack_lvl),
      .iackin_n(ackout_a), .iackout_n(ackout_b), .dtack_n(dtack_b),
      .data_o(data_b), .data_oe(oe_b));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_a();
      ev_a = 1'b1; tick(); ev_a = 1'b0;
   endtask

   task automatic start_cycle(input logic [2:0] l);
      ack_lvl = l; as_n = 1'b0; chain_in_n = 1'b0;
   endtask

   task automatic end_cycle();
      as_n = 1'b1; chain_in_n = 1'b1; tick(); tick();
   endtask

   task automatic t_reset();
      chk("R1 irq", irq_a, 7'h7F);
      chk("R1 iackout", ackout_a, 1);
      chk("R1 dtack", dtack_a, 1);
      chk("R1 oe", oe_a, 0);
   endtask

   task automatic t_levels();
      lvl_a = 3'd1; pulse_a();
      chk("R2 level1", irq_a, 7'b1111110);
      start_cycle(3'd1); tick(); end_cycle();
      lvl_a = 3'd7; pulse_a();
      chk("R2 level7", irq_a, 7'b0111111);
      start_cycle(3'd7); tick(); end_cycle();
      lvl_a = 3'd3; pulse_a();
      chk("R2 level3", irq_a, 7'b1111011);
      repeat (5) tick();
      chk("R4 held", irq_a, 7'b1111011);
   endtask

   task automatic t_serve();
      start_cycle(3'd3); tick();
      chk("R5 dtack", dtack_a, 0);
      chk("R5 oe", oe_a, 1);
      chk("R5 data", data_a, 8'hA5);
      chk("R5 iackout", ackout_a, 1);
      chk("R6 release", irq_a, 7'h7F);
      ack_lvl = 3'd6; tick();
      chk("R8 serve frozen", dtack_a, 0);
      as_n = 1'b1; chain_in_n = 1'b1; tick();
      chk("R8 idle dtack", dtack_a, 1);
      chk("R8 idle oe", oe_a, 0);
      tick();
   endtask

   task automatic t_disabled();
      lvl_a = 3'd0; pulse_a(); tick();
      chk("R3 ignored", irq_a, 7'h7F);
      start_cycle(3'd0); tick();
      chk("R7 disabled passes", ackout_a, 0);
      chk("R7 disabled dtack", dtack_a, 1);
      end_cycle();
   endtask

   task automatic t_mismatch();
      lvl_a = 3'd5; pulse_a();
      start_cycle(3'd2); tick();
      chk("R7 pass", ackout_a, 0);
      chk("R7 dtack", dtack_a, 1);
      chk("R7 oe", oe_a, 0);
      chk("R7 data", data_a, 0);
      chk("R7 irq kept", irq_a, 7'b1101111);
      ack_lvl = 3'd5; tick();
      chk("R8 pass frozen", ackout_a, 0);
      chk("R8 no late serve", dtack_a, 1);
      end_cycle();
      chk("R8 chain idle", ackout_a, 1);
      start_cycle(3'd5); tick();
      chk("R5 served after mismatch", data_a, 8'hA5);
      end_cycle();
      start_cycle(3'd5); tick();
      chk("R7 not pending passes", ackout_a, 0);
      end_cycle();
   endtask

   task automatic t_rearm();
      lvl_a = 3'd2; pulse_a();
      start_cycle(3'd2); ev_a = 1'b1; tick(); ev_a = 1'b0;
      chk("R10 dtack", dtack_a, 0);
      chk("R10 rearmed", irq_a, 7'b1111101);
      end_cycle();
      chk("R10 still asserted", irq_a, 7'b1111101);
      start_cycle(3'd2); tick();
      chk("R6 cleared", irq_a, 7'h7F);
      end_cycle();
   endtask

   task automatic t_chain();
      lvl_a = 3'd4; lvl_b = 3'd4;
      ev_a = 1'b1; ev_b = 1'b1; tick(); ev_a = 1'b0; ev_b = 1'b0;
      start_cycle(3'd4); tick(); tick();
      chk("R9 upstream serves", data_a, 8'hA5);
      chk("R9 downstream quiet", dtack_b, 1);
      chk("R9 downstream oe", oe_b, 0);
      chk("R9 downstream kept", irq_b, 7'b1110111);
      end_cycle();
      start_cycle(3'd4); tick();
      chk("R9 upstream passes", ackout_a, 0);
      chk("R9 downstream not yet", dtack_b, 1);
      tick();
      chk("R9 downstream serves", dtack_b, 0);
      chk("R9 downstream data", data_b, 8'h3C);
      chk("R9 upstream no dtack", dtack_a, 1);
      chk("R9 downstream released", irq_b, 7'h7F);
      end_cycle();
   endtask

   initial begin
      repeat (3) tick();
      t_reset();
      rst_n = 1'b1; tick();
      t_reset();
      t_levels();
      t_serve();
      t_disabled();
      t_mismatch();
      t_rearm();
      t_chain();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule